// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the slave end of a byte-wide serial memory on a four-wire SPI bus. The wires are chip select (active low), serial clock, data in and data out. Behind the bus sits an internal byte array of 4096 locations by default. All bus pins are brought into the block's system clock domain through synchronisers. The serial clock is then handled as a sampled signal, so the block keeps to one clock and one reset. Because of this, the serial clock must run several times slower than the system clock.

Each frame opens with chip select going low. The first eight bits received form an instruction. Depending on the instruction, a two-byte address and then data bytes follow.

- A read streams bytes out of the array and advances the address after each byte. The address wraps from the top of the array back to zero.
- A status read returns the busy flag, the write-enable latch and the block-protect level. It is accepted even while a write is in progress.
- A write stores bytes inside one 32-byte page. Writing needs the latch, which is armed only when chip select rises at the end of a frame that held nothing but the enable instruction. Bytes aimed at the protected region are refused.
- After a write, the busy flag holds for a fixed number of system clocks. During that time every instruction other than the status read is ignored.

The SPI bus has no back-pressure of its own, so the block has no valid/ready interface. The bus master sets the pace of all data.

Top module: `spi_eeprom`

## Requirements
- R1: Bits on the data-in line are sampled on rising edges of the serial clock while chip select is low, most significant bit first. The first 8 bits form the instruction. The serial clock may idle low (mode 0) or high (mode 3); both give identical results.
- R2: Read instruction 8'h03 is followed by a 16-bit address. Only the low 12 address bits are used; the upper 4 are ignored. Data bits then leave on the data-out line, most significant bit first, changing on falling edges of the serial clock. The first data bit is valid before the rising edge that follows the 24th bit.
- R3: While clocking continues, each further byte of a read comes from the next address. After address 12'hFFF, the next byte comes from address 12'h000.
- R4: Status-read instruction 8'h05 returns the byte {4'b0000, bp[1:0], wel, busy} and repeats it for as long as clocking continues. It is accepted while busy is 1.
- R5: The output-enable pin is 1 only while the block is sending read or status data within a frame. It is 0 whenever chip select is high.
- R6: After reset the write-enable latch is 0. Instruction 8'h06 sets the latch only if chip select rises after exactly those 8 bits. An enable followed by a write in the same frame leaves the latch at 0 and the array unchanged.
- R7: Write instruction 8'h02, followed by a 16-bit address, stores each following complete byte when the latch is 1 and busy is 0. The low 5 address bits advance after each byte and wrap inside the 32-byte page, while the upper address bits stay fixed.
- R8: The block-protect field protects a region of the array. Code 00 protects nothing, 01 addresses 12'hC00 to 12'hFFF, 10 addresses 12'h800 to 12'hFFF, and 11 the whole array. Protected bytes are not stored. A write frame that stores no byte leaves busy at 0 and the latch unchanged.
- R9: When chip select rises on a write frame that stored at least one byte, busy becomes 1 for BUSY_CYC system clocks. The latch clears as busy falls. While busy is 1, every instruction except 8'h05 is ignored: no data is driven and nothing is stored.
- R10: Instruction 8'h01 followed by one byte loads bits 3:2 of that byte into the block-protect field when the latch is 1 and busy is 0. The latch clears when chip select rises on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block; 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for the data-out pad (1 = driving) |

## Verification
The assertions check the following on every cycle:
- the data-out enable stays low while chip select has been high for several clocks;
- no array byte is stored while busy is set, without the latch, or under full protection;
- the latch rises only while idle and is clear once busy falls.

The bench's scenarios are the only place that shows the byte-level results. These are the read stream with its address wrap and page-wrapped writes. They also cover the ignored upper address bits and the refusal of an enable followed by a write in one frame. Finally, they cover protected writes that leave the array unchanged, and identical results in both clock idle polarities.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // Protection decision from the level and the two top address bits
  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (top2 == 2'b11);
      2'b10:   prot_hit = top2[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [SYNC-1:0] csn_q, sck_q, mosi_q;
  logic csn_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
      csn_d  <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      csn_q  <= {csn_q[SYNC-2:0], spi_csn};
      sck_q  <= {sck_q[SYNC-2:0], spi_sck};
      mosi_q <= {mosi_q[SYNC-2:0], spi_mosi};
      csn_d  <= csn_q[SYNC-1];
      sck_d  <= sck_q[SYNC-1];
    end
  end

  assign cs_act   = !csn_q[SYNC-1];
  assign cs_rise  = csn_q[SYNC-1] && !csn_d;
  assign sck_rise = cs_act && sck_q[SYNC-1] && !sck_d;
  assign sck_fall = cs_act && !sck_q[SYNC-1] && sck_d;
  assign mosi_s   = mosi_q[SYNC-1];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [7:0]        status,
  input  logic              busy,
  input  logic              wel,
  input  logic [1:0]        bp,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              wren_commit,
  output logic              wr_commit,
  output logic              sr_we,
  output logic [1:0]        sr_bp,
  output logic              sr_commit,
  output logic              miso,
  output logic              miso_oe
);
  localparam int HI_W = ADDR_W - 8;

  logic [6:0]        sin;
  logic [2:0]        bitc;
  logic [1:0]        bytec;
  logic [7:0]        op;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] wptr, raddr;
  logic              wrote, sr_seen, out_en;
  logic [2:0]        obit;
  logic [7:0]        sout;
  logic [7:0]        byte_in;
  logic              byte_done;
  logic [PAGE_W-1:0] pg_nxt;

  assign byte_in   = {sin, mosi_s};
  assign byte_done = sck_rise && (bitc == 3'd7);
  assign pg_nxt    = wptr[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    arr_we      = byte_done && (bytec == 2'd3) && (op == OP_WRITE) && wel && !busy &&
                  !prot_hit(bp, wptr[ADDR_W-1 -: 2]);
    arr_waddr   = wptr;
    arr_wdata   = byte_in;
    sr_we       = byte_done && (bytec == 2'd1) && (op == OP_WRSR) && wel && !busy;
    sr_bp       = byte_in[3:2];
    wren_commit = cs_rise && (op == OP_WREN) && (bytec == 2'd1) && (bitc == 3'd0);
    wr_commit   = cs_rise && wrote;
    sr_commit   = cs_rise && sr_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin <= '0; bitc <= '0; bytec <= '0; op <= '0; addr_hi <= '0;
      wptr <= '0; raddr <= '0; wrote <= 1'b0; sr_seen <= 1'b0;
      out_en <= 1'b0; obit <= '0; sout <= '0;
    end else if (!cs_act) begin
      sin <= '0; bitc <= '0; bytec <= '0; op <= '0;
      wrote <= 1'b0; sr_seen <= 1'b0; out_en <= 1'b0; obit <= '0;
    end else begin
      if (sck_rise) begin
        sin  <= byte_in[6:0];
        bitc <= bitc + 3'd1;
      end
      if (byte_done) begin
        case (bytec)
          2'd0: begin
            op    <= (busy && byte_in != OP_RDSR) ? 8'h00 : byte_in;
            bytec <= 2'd1;
            if (byte_in == OP_RDSR) out_en <= 1'b1;
          end
          2'd1: begin
            addr_hi <= byte_in[HI_W-1:0];
            bytec   <= 2'd2;
            if (sr_we) sr_seen <= 1'b1;
          end
          2'd2: begin
            raddr <= {addr_hi, byte_in};
            wptr  <= {addr_hi, byte_in};
            bytec <= 2'd3;
            if (op == OP_READ) out_en <= 1'b1;
          end
          default: begin
            if (op == OP_WRITE) wptr <= {wptr[ADDR_W-1:PAGE_W], pg_nxt};
            if (arr_we) wrote <= 1'b1;
          end
        endcase
      end
      if (sck_fall && out_en) begin
        obit <= obit + 3'd1;
        if (obit == 3'd0) begin
          sout <= (op == OP_RDSR) ? status : mem_rdata;
          if (op == OP_READ) raddr <= raddr + ADDR_W'(1);
        end else begin
          sout <= {sout[6:0], 1'b0};
        end
      end
    end
  end

  assign mem_raddr = raddr;
  assign miso_oe   = out_en && cs_act;
  assign miso      = miso_oe && sout[7];
endmodule

// File: rtl/spi_ee_stat.sv
module spi_ee_stat #(
  parameter int BUSY_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren_commit,
  input  logic       wr_commit,
  input  logic       sr_we,
  input  logic [1:0] sr_bp,
  input  logic       sr_commit,
  output logic       wel,
  output logic [1:0] bp,
  output logic       busy,
  output logic [7:0] status
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      wel <= 1'b0;
      bp  <= 2'b00;
    end else begin
      if (wr_commit) cnt <= CW'(BUSY_CYC);
      else if (cnt != '0) cnt <= cnt - CW'(1);
      if (wren_commit) wel <= 1'b1;
      else if (sr_commit || (!wr_commit && cnt == CW'(1))) wel <= 1'b0;
      if (sr_we) bp <= sr_bp;
    end
  end

  assign busy   = (cnt != '0);
  assign status = {4'b0000, bp, wel, busy};
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 5,
  parameter int BUSY_CYC = 1000,
  parameter int SYNC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic cs_act, cs_rise, sck_rise, sck_fall, mosi_s;
  logic [7:0] status, mem_rdata, arr_wdata;
  logic busy, wel, arr_we, wren_commit, wr_commit, sr_we, sr_commit;
  logic [1:0] bp, sr_bp;
  logic [ADDR_W-1:0] mem_raddr, arr_waddr;

  spi_ee_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s)
  );

  spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .status(status), .busy(busy), .wel(wel),
    .bp(bp), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .wren_commit(wren_commit),
    .wr_commit(wr_commit), .sr_we(sr_we), .sr_bp(sr_bp), .sr_commit(sr_commit),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_ee_stat #(.BUSY_CYC(BUSY_CYC)) u_stat (
    .clk(clk), .rst_n(rst_n), .wren_commit(wren_commit), .wr_commit(wr_commit),
    .sr_we(sr_we), .sr_bp(sr_bp), .sr_commit(sr_commit), .wel(wel), .bp(bp),
    .busy(busy), .status(status)
  );

  spi_ee_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_csn,
  input logic       spi_miso_oe,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp,
  input logic       arr_we
);
  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn, 1) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);
  // R9
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_we);
  // R7
  write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wel);
  // R8
  full_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 2'b11) |-> !arr_we);
  // R9
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R6
  wel_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> (!busy && spi_csn));
endmodule

bind spi_eeprom spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso_oe(spi_miso_oe),
  .busy(busy), .wel(wel), .bp(bp), .arr_we(arr_we)
);

// File: tb/spi_eeprom_test.sv
module spi_eeprom_test;
  localparam int HP = 6;
  localparam int BUSY = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic mode3 = 1'b0;
  int nchk = 0, nerr = 0;

  logic [7:0] ref_mem [4096];
  logic wel_m = 1'b0, busy_m = 1'b0;
  logic [1:0] bp_m = 2'b00;

  always #10 clk = ~clk;

  spi_eeprom uut (.clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r, output logic o);
    if (mode3) spi_sck = 1'b0;
    spi_mosi = b;
    wclk(HP);
    r = spi_miso;
    o = spi_miso_oe;
    spi_sck = 1'b1;
    wclk(HP);
    if (!mode3) spi_sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all,
                       output logic oe_any);
    logic r, o;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r, o);
      rx[i] = r;
      oe_all &= o;
      oe_any |= o;
    end
  endtask

  task automatic cs_lo();
    spi_sck = mode3;
    wclk(HP);
    spi_csn = 1'b0;
    wclk(HP);
  endtask

  task automatic cs_hi(input string tag);
    wclk(HP);
    spi_csn = 1'b1;
    wclk(4 * HP);
    check(spi_miso_oe == 1'b0, {tag, " R5 oe low after frame"}, int'(spi_miso_oe), 0);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] rx; logic a, y;
    xbyte(b, rx, a, y);
  endtask

  function automatic logic [7:0] st_m();
    return {4'b0000, bp_m, wel_m, busy_m};
  endfunction

  function automatic logic prot_m(input int a);
    case (bp_m)
      2'b00: return 1'b0;
      2'b01: return a >= 'hC00;
      2'b10: return a >= 'h800;
      default: return 1'b1;
    endcase
  endfunction

  task automatic rdsr(input string tag);
    logic [7:0] rx; logic a, y;
    cs_lo();
    send(8'h05);
    for (int k = 0; k < 2; k++) begin
      xbyte(8'h00, rx, a, y);
      check(rx == st_m() && a, {tag, " R4 status"}, int'(rx), int'(st_m()));
    end
    cs_hi(tag);
  endtask

  task automatic wren();
    cs_lo(); send(8'h06); cs_hi("wren");
    if (!busy_m) wel_m = 1'b1;
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); send(8'h01); send(v); cs_hi("wrsr");
    if (wel_m && !busy_m) begin
      bp_m = v[3:2];
      wel_m = 1'b0;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d[$]);
    int p = a & 'hFFF;
    logic any = 1'b0;
    cs_lo();
    send(8'h02); send(8'(a >> 8)); send(8'(a));
    foreach (d[k]) begin
      send(d[k]);
      if (wel_m && !busy_m && !prot_m(p)) begin
        ref_mem[p] = d[k];
        any = 1'b1;
      end
      p = (p & 'hFE0) | ((p + 1) & 'h1F);
    end
    cs_hi("write");
    if (any) busy_m = 1'b1;
  endtask

  task automatic wait_done();
    wclk(BUSY + 50);
    if (busy_m) begin
      busy_m = 1'b0;
      wel_m = 1'b0;
    end
  endtask

  task automatic rd(input int a, input int n, input string tag);
    logic [7:0] rx, e; logic al, an;
    cs_lo();
    send(8'h03); send(8'(a >> 8)); send(8'(a));
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rx, al, an);
      if (busy_m) begin
        check(!an, {tag, " R9 no output while busy"}, int'(an), 0);
      end else begin
        e = ref_mem[(a + k) & 'hFFF];
        check(rx == e && al, tag, int'(rx), int'(e));
      end
    end
    cs_hi(tag);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    check(spi_miso_oe == 1'b0, "R5 oe low after reset", int'(spi_miso_oe), 0);
    rdsr("R6 reset status");

    wren();
    rdsr("R6 latch set");
    wr('h0FFE, '{8'hAA, 8'hBB, 8'hCC, 8'hDD});
    rdsr("R9 busy during write");
    rd('h0FFE, 1, "R9 read ignored while busy");
    wait_done();
    rdsr("R9 busy done latch cleared");

    wren();
    wr('h0000, '{8'h11, 8'h22});
    wait_done();
    rd('h0FFE, 4, "R3 sequential read wrap");
    rd('h0FE0, 2, "R7 page wrap");
    rd('hF001, 1, "R2 upper address ignored");

    cs_lo(); send(8'h06); send(8'h02); send(8'h00); send(8'h00); send(8'h55);
    cs_hi("R6 same frame");
    rdsr("R6 same frame latch clear");
    rd('h0000, 1, "R6 same frame array unchanged");

    wren();
    wr('h0C00, '{8'h5A});
    wait_done();
    wren();
    wrsr(8'h04);
    rdsr("R10 protect level loaded");
    wren();
    wr('h0C00, '{8'hA5});
    rdsr("R8 protected write no busy");
    rd('h0C00, 1, "R8 protected byte kept");
    wr('h0800, '{8'h77});
    rdsr("R8 unprotected write busy");
    wait_done();
    rd('h0800, 1, "R8 unprotected byte stored");

    wren();
    wrsr(8'h0C);
    wren();
    wr('h0000, '{8'h99});
    rdsr("R8 whole array protected");
    rd('h0000, 1, "R8 whole array kept");
    wrsr(8'h00);
    rdsr("R10 protect cleared");

    mode3 = 1'b1;
    rd('h0FFE, 3, "R1 mode 3 read");
    rdsr("R1 mode 3 status");
    wren();
    wr('h0010, '{8'h3C});
    wait_done();
    mode3 = 1'b0;
    rd('h0010, 1, "R1 mode 3 write then mode 0 read");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    wclk(190000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule